// File: doc/BRIEF.md
# Relative-Address Butterfly Switching Network

This block is a single-pass interconnect between eight endpoints. It is made of three ranks of two-by-two switching elements. Every input line offers at most one packet per clock. A packet carries a valid bit, a 3-bit source index, a 3-bit destination index and a data word. On entry the block XORs the source with the destination to form a relative routing tag. Each rank reads one tag bit and either passes the packet straight or swaps it across to the partner line. Because only the bits in which source and destination differ get flipped, a packet injected on its own source line leaves on its destination line. Every pair of endpoints takes exactly three element traversals.

The ranks are not buffered, so two packets can ask for the same element output. The element then gives the output to the packet on the lower-numbered line and discards the other. The discarded packet is reported on a per-input blocked flag. Results are registered once, so delivered packets and blocked flags appear together one clock after the inputs.

The data path is a valid-only stream with no back-pressure. There is no ready signal. The network accepts a full set of inputs on every clock and never stalls. A packet that cannot be delivered is dropped and reported, not held. The sender must re-offer a blocked packet if it still needs delivery.

Top module: `xor_butterfly`

## Requirements
- R1: The routing tag is `src ^ dst`. Rank i (i = 0, 1, 2, applied in that order) pairs the lines whose indices differ only in bit i. A tag bit i of 0 keeps the packet on its line, and 1 moves it to the partner line, which flips bit i of its line index.
- R2: A packet entering on line L that is not blocked leaves on line `L ^ src ^ dst`, so it leaves on line `dst` when `src == L`. Its src, dst and data leave unchanged.
- R3: Outputs are registered. A packet offered at one rising edge is visible on the outputs right after that edge, and the next edge replaces it. There is no ready input, and a new set of packets is accepted at every edge.
- R4: When two packets at one element want the same output, the packet on the lower-numbered line of that element wins. The other packet is dropped, and `out_blocked` is raised at the bit equal to the dropped packet's input line, in the same cycle as the outputs.
- R5: Every valid input is either delivered on exactly one output line or flagged blocked, never both. `out_blocked` is never raised for an input whose valid was low.
- R6: If every valid input has an all-zero tag (`src == dst`), every packet passes straight through to its own line number and nothing is blocked.
- R7: While reset is high, at the next edge and after it, `out_valid` and `out_blocked` are all zero.
- R8: A packet from 4 to 6 (tag 010: straight, across, straight) leaves on line 6.
- R9: An input whose valid is low is ignored. Its src, dst and data fields cannot block or displace any other packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Packet present on input line k (bit k) |
| in_src | input | 24 | Source index, 3 bits per line, line k at [3k+2:3k] |
| in_dst | input | 24 | Destination index, 3 bits per line, line k at [3k+2:3k] |
| in_data | input | 128 | Data word, 16 bits per line, line k at [16k+15:16k] |
| out_valid | output | 8 | Packet delivered on output line k |
| out_src | output | 24 | Source index of the packet on output line k |
| out_dst | output | 24 | Destination index of the packet on output line k |
| out_data | output | 128 | Data word of the packet on output line k |
| out_blocked | output | 8 | Bit k: the packet offered on input line k lost a conflict |

## Verification
Four properties are checked on every cycle. Each delivered packet sits on the line given by its entry line XOR its tag. The delivered and blocked counts add up to the number of valid inputs. Blocked flags appear only for lines that were valid. An offer made entirely of zero tags comes out as pure pass-through. The bench scenarios are what show the rest. They check which of two contending packets wins and that payload fields arrive intact. They check that the 4-to-6 example and uniform-shift permutations deliver every packet, and that a lane with valid low never disturbs its partner.

// File: rtl/xbf_pkg.sv
package xbf_pkg;
  parameter int ADDR_W = 3;
  parameter int DATA_W = 16;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] tag;
    logic [ADDR_W-1:0] org;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [DATA_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/xbf_elem.sv
module xbf_elem
  import xbf_pkg::*;
#(
  parameter int STG = 0
) (
  input  pkt_t              lo_i,
  input  pkt_t              hi_i,
  output pkt_t              lo_o,
  output pkt_t              hi_o,
  output logic              lost_o,
  output logic [ADDR_W-1:0] lost_org_o
);
  logic lo_keep, lo_swap, hi_keep, hi_swap;

  // R1: tag bit STG chooses straight (0) or across (1)
  assign lo_keep = lo_i.vld & ~lo_i.tag[STG];
  assign lo_swap = lo_i.vld &  lo_i.tag[STG];
  assign hi_keep = hi_i.vld & ~hi_i.tag[STG];
  assign hi_swap = hi_i.vld &  hi_i.tag[STG];

  // R4: the lower line is considered first for both outputs
  always_comb begin
    lo_o = '0;
    hi_o = '0;
    if (lo_keep)      lo_o = lo_i;
    else if (hi_swap) lo_o = hi_i;
    if (lo_swap)      hi_o = lo_i;
    else if (hi_keep) hi_o = hi_i;
  end

  assign lost_o     = (lo_keep & hi_swap) | (lo_swap & hi_keep);
  assign lost_org_o = hi_i.org;
endmodule

// File: rtl/xbf_stage.sv
module xbf_stage
  import xbf_pkg::*;
#(
  parameter int STG   = 0,
  parameter int LINES = 8
) (
  input  pkt_t             lines_i [LINES],
  output pkt_t             lines_o [LINES],
  output logic [LINES-1:0] drop_o
);
  localparam int HALF = LINES / 2;

  logic              lost_w [HALF];
  logic [ADDR_W-1:0] org_w  [HALF];

  for (genvar j = 0; j < HALF; j++) begin : g_elem
    localparam int LO = ((j >> STG) << (STG + 1)) | (j & ((1 << STG) - 1));
    localparam int HI = LO | (1 << STG);
    xbf_elem #(.STG(STG)) u_elem (
      .lo_i       (lines_i[LO]),
      .hi_i       (lines_i[HI]),
      .lo_o       (lines_o[LO]),
      .hi_o       (lines_o[HI]),
      .lost_o     (lost_w[j]),
      .lost_org_o (org_w[j])
    );
  end

  always_comb begin
    drop_o = '0;
    for (int j = 0; j < HALF; j++)
      if (lost_w[j]) drop_o[org_w[j]] = 1'b1;
  end
endmodule

// File: rtl/xor_butterfly.sv
module xor_butterfly
  import xbf_pkg::*;
#(
  parameter int LINES = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LINES-1:0]         in_valid,
  input  logic [LINES*ADDR_W-1:0]  in_src,
  input  logic [LINES*ADDR_W-1:0]  in_dst,
  input  logic [LINES*DATA_W-1:0]  in_data,
  output logic [LINES-1:0]         out_valid,
  output logic [LINES*ADDR_W-1:0]  out_src,
  output logic [LINES*ADDR_W-1:0]  out_dst,
  output logic [LINES*DATA_W-1:0]  out_data,
  output logic [LINES-1:0]         out_blocked
);
  localparam int STAGES = ADDR_W;
  localparam int CNT_W  = ADDR_W + 1;

  pkt_t             net    [STAGES+1][LINES];
  logic [LINES-1:0] drop_s [STAGES];
  logic [LINES-1:0] drop_all;
  logic             zero_tags;

  // R1: relative tag formed at injection
  for (genvar k = 0; k < LINES; k++) begin : g_inj
    always_comb begin
      net[0][k].vld  = in_valid[k];
      net[0][k].src  = in_src[k*ADDR_W +: ADDR_W];
      net[0][k].dst  = in_dst[k*ADDR_W +: ADDR_W];
      net[0][k].tag  = in_src[k*ADDR_W +: ADDR_W] ^ in_dst[k*ADDR_W +: ADDR_W];
      net[0][k].org  = ADDR_W'(k);
      net[0][k].data = in_data[k*DATA_W +: DATA_W];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    xbf_stage #(.STG(s), .LINES(LINES)) u_stage (
      .lines_i (net[s]),
      .lines_o (net[s+1]),
      .drop_o  (drop_s[s])
    );
  end

  always_comb begin
    drop_all  = '0;
    zero_tags = 1'b1;
    for (int s = 0; s < STAGES; s++) drop_all |= drop_s[s];
    for (int k = 0; k < LINES; k++)
      if (in_valid[k] && (net[0][k].tag != '0)) zero_tags = 1'b0;
  end

  // R3: single output register rank
  logic [ADDR_W-1:0] org_q [LINES];
  logic [LINES-1:0]  inval_q;
  logic              zero_q;
  logic [CNT_W-1:0]  nin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= '0;
      out_blocked <= '0;
      inval_q     <= '0;
      zero_q      <= 1'b0;
      nin_q       <= '0;
    end else begin
      out_blocked <= drop_all;
      inval_q     <= in_valid;
      zero_q      <= zero_tags;
      nin_q       <= CNT_W'($countones(in_valid));
      for (int k = 0; k < LINES; k++) out_valid[k] <= net[STAGES][k].vld;
    end
  end

  for (genvar k = 0; k < LINES; k++) begin : g_out
    always_ff @(posedge clk) begin
      out_src[k*ADDR_W +: ADDR_W]  <= net[STAGES][k].src;
      out_dst[k*ADDR_W +: ADDR_W]  <= net[STAGES][k].dst;
      out_data[k*DATA_W +: DATA_W] <= net[STAGES][k].data;
      org_q[k]                     <= net[STAGES][k].org;
    end

    AST_DELIVER_LINE: assert property (@(posedge clk) disable iff (rst)
      out_valid[k] |-> ((org_q[k] ^ out_src[k*ADDR_W +: ADDR_W] ^ out_dst[k*ADDR_W +: ADDR_W]) == ADDR_W'(k)))
      else $error("delivery line mismatch"); // R2
  end

  AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    (CNT_W'($countones(out_valid)) + CNT_W'($countones(out_blocked))) == nin_q)
    else $error("packet count mismatch"); // R5

  AST_BLOCK_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_blocked & ~inval_q) == '0)
    else $error("blocked flag on idle lane"); // R9

  AST_ZERO_TAG_PASS: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (out_valid == inval_q && out_blocked == '0))
    else $error("zero tags not pass-through"); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && out_blocked == '0))
    else $error("outputs active after reset"); // R7
endmodule

// File: tb/xor_butterfly_tb.sv
`timescale 1ns/1ps
module xor_butterfly_tb;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NL = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NL-1:0]   in_valid = '0;
  logic [NL*AW-1:0] in_src = '0, in_dst = '0;
  logic [NL*DW-1:0] in_data = '0;
  logic [NL-1:0]   out_valid, out_blocked;
  logic [NL*AW-1:0] out_src, out_dst;
  logic [NL*DW-1:0] out_data;

  always #2 clk = ~clk;

  xor_butterfly u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst),
    .in_data(in_data), .out_valid(out_valid), .out_src(out_src), .out_dst(out_dst),
    .out_data(out_data), .out_blocked(out_blocked)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit            v_a [NL];
  logic [AW-1:0] s_a [NL];
  logic [AW-1:0] d_a [NL];
  logic [DW-1:0] p_a [NL];

  bit            ev  [NL];
  int            eorg[NL];
  bit            eblk[NL];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference: walk the ranks, lower line served first
  task automatic model();
    bit occ [NL];
    int who [NL];
    bit nocc[NL];
    int nwho[NL];
    for (int k = 0; k < NL; k++) begin
      occ[k] = v_a[k]; who[k] = k; eblk[k] = 0;
    end
    for (int s = 0; s < AW; s++) begin
      for (int k = 0; k < NL; k++) begin nocc[k] = 0; nwho[k] = 0; end
      for (int k = 0; k < NL; k++) begin
        if (occ[k]) begin
          logic [AW-1:0] t;
          int dest;
          t = s_a[who[k]] ^ d_a[who[k]];
          dest = k ^ (int'(t[s]) << s);
          if (!nocc[dest]) begin nocc[dest] = 1; nwho[dest] = who[k]; end
          else eblk[who[k]] = 1;
        end
      end
      for (int k = 0; k < NL; k++) begin occ[k] = nocc[k]; who[k] = nwho[k]; end
    end
    for (int k = 0; k < NL; k++) begin ev[k] = occ[k]; eorg[k] = who[k]; end
  endtask

  task automatic apply(input string req);
    for (int k = 0; k < NL; k++) begin
      in_valid[k]           = v_a[k];
      in_src[k*AW +: AW]    = s_a[k];
      in_dst[k*AW +: AW]    = d_a[k];
      in_data[k*DW +: DW]   = p_a[k];
    end
    model();
    @(negedge clk);
    for (int k = 0; k < NL; k++) begin
      chk(out_valid[k] == ev[k], req, $sformatf("out_valid[%0d]", k), int'(out_valid[k]), int'(ev[k]));
      chk(out_blocked[k] == eblk[k], req, $sformatf("out_blocked[%0d]", k), int'(out_blocked[k]), int'(eblk[k]));
      if (ev[k] && out_valid[k]) begin
        chk(out_dst[k*AW +: AW] == d_a[eorg[k]], req, $sformatf("out_dst[%0d]", k),
            int'(out_dst[k*AW +: AW]), int'(d_a[eorg[k]]));
        chk(out_src[k*AW +: AW] == s_a[eorg[k]], req, $sformatf("out_src[%0d]", k),
            int'(out_src[k*AW +: AW]), int'(s_a[eorg[k]]));
        chk(out_data[k*DW +: DW] == p_a[eorg[k]], req, $sformatf("out_data[%0d]", k),
            int'(out_data[k*DW +: DW]), int'(p_a[eorg[k]]));
      end
    end
  endtask

  task automatic clear_lanes();
    for (int k = 0; k < NL; k++) begin
      v_a[k] = 0; s_a[k] = AW'(k); d_a[k] = AW'(k); p_a[k] = DW'($urandom);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(out_valid == '0, "R7", "out_valid in reset", int'(out_valid), 0);
    chk(out_blocked == '0, "R7", "out_blocked in reset", int'(out_blocked), 0);
    rst = 1'b0;

    // R6: all-zero tags, full load
    clear_lanes();
    for (int k = 0; k < NL; k++) v_a[k] = 1;
    apply("R6");

    // R8: single 4 -> 6
    clear_lanes();
    v_a[4] = 1; d_a[4] = 3'd6;
    apply("R8");
    chk(out_valid[6] == 1'b1, "R8", "line 6 valid", int'(out_valid[6]), 1);

    // R4: line 0 crosses into line 1 while line 1 stays; lower line wins
    clear_lanes();
    v_a[0] = 1; d_a[0] = 3'd1;
    v_a[1] = 1; d_a[1] = 3'd1;
    apply("R4");
    chk(out_blocked[1] == 1'b1, "R4", "loser is line 1", int'(out_blocked[1]), 1);

    // R4: conflict in the last rank only (lines 2 and 6 both to 6)
    clear_lanes();
    v_a[2] = 1; d_a[2] = 3'd6;
    v_a[6] = 1; d_a[6] = 3'd6;
    apply("R4");

    // R9: idle lane with conflicting fields is ignored
    clear_lanes();
    v_a[0] = 1; d_a[0] = 3'd1;
    v_a[1] = 0; d_a[1] = 3'd1;
    apply("R9");
    chk(out_valid[1] == 1'b1 && out_blocked == '0, "R9", "idle lane no effect", int'(out_blocked), 0);

    // R1 / R2: uniform xor shifts are permutations with no conflicts
    for (int m = 1; m < NL; m++) begin
      clear_lanes();
      for (int k = 0; k < NL; k++) begin v_a[k] = 1; d_a[k] = AW'(k ^ m); end
      apply("R1");
      chk(out_blocked == '0, "R2", "uniform shift blocks", int'(out_blocked), 0);
    end

    // R2: entry line differs from src field
    clear_lanes();
    v_a[3] = 1; s_a[3] = 3'd0; d_a[3] = 3'd5;
    apply("R2");
    chk(out_valid[6] == 1'b1, "R2", "line 3^0^5 valid", int'(out_valid[6]), 1);

    // R3 / R5: random back-to-back traffic
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < NL; k++) begin
        v_a[k] = 1'($urandom);
        s_a[k] = AW'(k);
        d_a[k] = AW'($urandom);
        p_a[k] = DW'($urandom);
      end
      apply("R5");
    end

    // R7: reset clears live outputs
    clear_lanes();
    for (int k = 0; k < NL; k++) v_a[k] = 1;
    for (int k = 0; k < NL; k++) in_valid[k] = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R7", "out_valid after reset", int'(out_valid), 0);
    chk(out_blocked == '0, "R7", "out_blocked after reset", int'(out_blocked), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule